// File: doc/BRIEF.md
# Receive Sync Hunter with Leading-Sync Strip

This block sits in the receive path of one synchronous serial line, after bit framing has assembled whole characters. It hunts for the line's programmed sync character and declares the receiver active once a run of consecutive sync characters has been seen. Every character that arrives while hunting is discarded, and so are the sync characters that achieve lock. After lock, the block can also remove any further sync characters that arrive before the first data character. That removal stops for good at the first non-sync character, and a status flag shows while it is still armed.

Software restarts the hunt with a one-cycle resync pulse. Resync also discards any character still waiting in the output stage. Disabling the receiver has the same effect for as long as the enable is low.

Both character interfaces are valid/ready. An input character transfers on a clock edge where `in_valid` and `in_ready` are both high. An output character transfers on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the one-entry output stage is empty or is being emptied in that cycle, so back-pressure reaches the input with no combinational path from `in_valid`. While `out_valid` is high and `out_ready` is low, the output character is held unchanged.

Top module: `sync_hunt_top`

## Requirements
- R1: After reset, `rx_active`, `strip_on` and `out_valid` are all 0.
- R2: Lock is reached when SYNC_HITS consecutive accepted characters (default 2) equal `sync_char`. `rx_active` goes to 1 on the clock edge that accepts the last of them.
- R3: A non-sync character accepted after a partial run of matches clears the run. SYNC_HITS fresh sync characters are then needed for lock.
- R4: No character accepted while `rx_active` is 0 is ever passed to the output, and this includes the characters that achieve lock.
- R5: If `strip_en` is 1 at the edge that achieves lock, `strip_on` becomes 1. While `strip_on` is 1, accepted sync characters are dropped and `strip_on` stays 1.
- R6: The first non-sync character accepted while `strip_on` is 1 is passed, and `strip_on` returns to 0 on that edge. Later sync characters are passed as data.
- R7: If `strip_en` is 0 at lock, `strip_on` stays 0 and a sync character accepted right after lock is passed.
- R8: A `resync` pulse clears `rx_active` and `strip_on`, discards the character held in the output stage, and drops any character accepted in the same cycle. The hunt then restarts with the match count at zero.
- R9: While `rx_en` is 0, `rx_active` is 0, accepted characters are dropped, and the output stage is emptied.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged. No passed character is lost or duplicated.
- R11: A passed character appears on `out_data` with `out_valid` 1 in the clock cycle after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the block in hunt and empties the output |
| resync | input | 1 | One-cycle pulse that restarts the hunt and flushes held data |
| sync_char | input | DATA_W | Programmed sync character |
| strip_en | input | 1 | Arms removal of leading sync characters at lock |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Block can accept an input character |
| in_data | input | DATA_W | Input character |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | Downstream accepts the output character |
| out_data | output | DATA_W | Output character |
| rx_active | output | 1 | Receiver has achieved sync |
| strip_on | output | 1 | Leading-sync removal is still armed |

## Verification
Resync can arrive in the same cycle as an accepted character, and it can arrive while a character waits in the output stage. The bench drives a sync character together with the resync pulse right after a first match. It then checks that the receiver does not lock and that one more sync character still leaves it unlocked. In a second case it stalls the output with `out_ready` low, pulses resync, and checks that `out_valid` has dropped and that the scoreboard never sees the flushed character.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/sync_hunt_ctrl.sv
module sync_hunt_ctrl
  import sync_hunt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_HITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              strip_en,
  input  logic              char_fire,
  input  logic [DATA_W-1:0] char_data,
  output logic              keep_char,
  output logic              rx_active,
  output logic              strip_on
);
  localparam int CNT_W = (SYNC_HITS < 2) ? 1 : $clog2(SYNC_HITS + 1);
  localparam logic [CNT_W-1:0] LAST_HIT = CNT_W'(SYNC_HITS - 1);

  hunt_state_e      state_q;
  logic [CNT_W-1:0] hits_q;
  logic             strip_q;
  logic             is_sync;

  assign is_sync   = (char_data == sync_char);
  assign rx_active = (state_q == ST_LOCKED);
  assign strip_on  = strip_q;
  assign keep_char = char_fire && !restart && rx_active && !(strip_q && is_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      hits_q  <= '0;
      strip_q <= 1'b0;
    end else if (restart) begin
      state_q <= ST_HUNT;
      hits_q  <= '0;
      strip_q <= 1'b0;
    end else if (char_fire) begin
      unique case (state_q)
        ST_HUNT: begin
          if (!is_sync) begin
            hits_q <= '0;
          end else if (hits_q == LAST_HIT) begin
            state_q <= ST_LOCKED;
            hits_q  <= '0;
            strip_q <= strip_en;
          end else begin
            hits_q <= hits_q + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (strip_q && !is_sync) strip_q <= 1'b0;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  // R8 / R9: a restart leaves the block unlocked with stripping disarmed
  p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!rx_active && !strip_on));

  // R5: stripping is only ever armed while locked
  p_strip_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strip_on |-> rx_active);

  // R5: a dropped leading sync keeps stripping armed
  p_strip_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_fire && strip_on && is_sync && !restart) |=> strip_on);

  // R6: stripping ends on a non-sync character
  p_strip_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_fire && strip_on && !is_sync && !restart) |=> !strip_on);
endmodule

// File: rtl/sync_hunt_ostage.sv
module sync_hunt_ostage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              can_take
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign can_take  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= load_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  // R8: a flush empties the stage
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  // R10: a stalled character is held unchanged
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/sync_hunt_top.sv
module sync_hunt_top #(
  parameter int DATA_W    = 8,
  parameter int SYNC_HITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              resync,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              strip_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              rx_active,
  output logic              strip_on
);
  logic restart;
  logic char_fire;
  logic keep_char;
  logic can_take;

  assign restart   = resync || !rx_en;
  assign in_ready  = can_take;
  assign char_fire = in_valid && can_take;

  sync_hunt_ctrl #(
    .DATA_W    (DATA_W),
    .SYNC_HITS (SYNC_HITS)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .sync_char (sync_char),
    .strip_en  (strip_en),
    .char_fire (char_fire),
    .char_data (in_data),
    .keep_char (keep_char),
    .rx_active (rx_active),
    .strip_on  (strip_on)
  );

  sync_hunt_ostage #(
    .DATA_W (DATA_W)
  ) ostage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (restart),
    .load      (keep_char),
    .load_data (in_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .can_take  (can_take)
  );

  // R11: a kept character is presented one clock after acceptance
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    keep_char |=> (out_valid && out_data == $past(in_data)));

  // R9: disabled receiver never reports lock
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_active);
endmodule

// File: tb/sync_hunt_top_tb_top.sv
module sync_hunt_top_tb_top;
  localparam int DW = 8;
  localparam logic [DW-1:0] SYN = 8'h96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          resync = 1'b0;
  logic [DW-1:0] sync_char = SYN;
  logic          strip_en = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          rx_active;
  logic          strip_on;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  logic rand_rdy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] expq[$];

  always #10 clk = ~clk;

  sync_hunt_top #(.DATA_W(DW), .SYNC_HITS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .resync(resync),
    .sync_char(sync_char), .strip_en(strip_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rx_active(rx_active), .strip_on(strip_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input logic [DW-1:0] d, input bit pass);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    do begin
      #1 ok = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
    if (pass) expq.push_back(d);
  endtask

  task automatic pulse_resync();
    resync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resync = 1'b0;
  endtask

  task automatic drain();
    rand_rdy = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R10 drain", expq.size(), 0);
  endtask

  // ready pattern generator
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rand_rdy) out_ready <= lfsr[0] | lfsr[3];
  end

  // monitor: scoreboard compare of each output transfer
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected output", out_data, 0);
        end else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk(out_data == e, "R10 data order", out_data, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rx_active && !strip_on && !out_valid, "R1 reset state",
        {rx_active, strip_on, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;

    // R3: mismatch after one match returns to hunt
    send(8'hA5, 0);
    send(SYN, 0);
    send(8'h11, 0);
    send(SYN, 0);
    chk(!rx_active, "R3 one match after reset of run", rx_active, 0);
    // R2: second consecutive sync locks
    send(SYN, 0);
    chk(rx_active, "R2 lock after two syncs", rx_active, 1);
    chk(!strip_on, "R7 strip stays off", strip_on, 0);
    // R7: sync right after lock passes
    send(SYN, 1);
    send(8'h41, 1);
    send(SYN, 1);
    drain();

    // R8: resync clears lock
    pulse_resync();
    chk(!rx_active, "R8 resync clears active", rx_active, 0);

    // R5: strip armed at lock
    strip_en = 1'b1;
    send(SYN, 0);
    send(SYN, 0);
    chk(rx_active && strip_on, "R5 strip armed at lock", {rx_active, strip_on}, 3);
    send(SYN, 0);
    send(SYN, 0);
    chk(strip_on, "R5 strip held over leading syncs", strip_on, 1);
    // R6: first data ends stripping
    send(8'h3C, 1);
    chk(!strip_on, "R6 strip ends on data", strip_on, 0);
    send(SYN, 1);
    send(8'h55, 1);
    drain();

    // R11: one-cycle latency
    send(8'hE7, 1);
    chk(out_valid && out_data == 8'hE7, "R11 latency", out_data, 8'hE7);
    drain();

    // R10: random back-pressure over a mixed stream
    rand_rdy = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] v;
      v = (i % 5 == 2) ? SYN : DW'(i * 37 + 5);
      send(v, 1);
      #1 chk(in_ready == (!out_valid || out_ready), "R10 ready rule", in_ready,
             !out_valid || out_ready);
      @(negedge clk);
    end
    drain();

    // R8: flush of a held character
    out_ready = 1'b0;
    send(8'h77, 0);
    chk(out_valid && out_data == 8'h77, "R10 stall holds", out_data, 8'h77);
    @(negedge clk);
    chk(out_valid && out_data == 8'h77, "R10 stall stable", out_data, 8'h77);
    pulse_resync();
    chk(!out_valid, "R8 flush held char", out_valid, 0);
    chk(!rx_active, "R8 resync unlocks", rx_active, 0);
    out_ready = 1'b1;
    strip_en = 1'b0;

    // R8: resync coincident with the locking sync
    send(SYN, 0);
    in_valid = 1'b1;
    in_data  = SYN;
    resync   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    resync   = 1'b0;
    chk(!rx_active, "R8 coincident resync blocks lock", rx_active, 0);
    send(SYN, 0);
    chk(!rx_active, "R8 match count restarted", rx_active, 0);
    send(SYN, 0);
    chk(rx_active, "R2 relock", rx_active, 1);
    send(8'h20, 1);
    drain();

    // R9: disabled receiver
    rx_en = 1'b0;
    @(negedge clk);
    chk(!rx_active, "R9 disable clears active", rx_active, 0);
    send(SYN, 0);
    send(SYN, 0);
    send(8'h42, 0);
    chk(!rx_active && !out_valid, "R9 disabled drops", {rx_active, out_valid}, 0);
    rx_en = 1'b1;
    send(SYN, 0);
    send(SYN, 0);
    chk(rx_active, "R9 hunt resumes after enable", rx_active, 1);
    drain();

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule